// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns four parallel audio sample words into one serial data line. An external master supplies the bit clock and the frame sync. Both arrive as plain inputs that are synchronous to the block's system clock, and the block follows their edges. A 2-bit format code selects among three framings. The first is a two-channel left-justified stream. The second is a two-channel I2S stream. The third is a four-slot time-division-multiplexed (TDM) frame. In TDM mode all four channels share the single data line within one frame-sync period.

Sample words are loaded through a parallel port with a one-cycle valid strobe. A new set of words waits in a staging register and moves to the active register only at a frame boundary. A load that arrives in the middle of a frame therefore never disturbs the frame being sent. The output bit changes only after a bit-clock falling edge, so a receiver can capture it on the next rising edge.

The frame sync is sampled at each bit-clock rising edge. A change in its value is seen at that rising edge. Bit period 0 of the new frame or half-frame is the bit period that starts at the next bit-clock falling edge.

Top module: `audio_serial_tx`

## Requirements
- R1: After reset `sdout` is 0. The active sample words are all zero until the first load has been latched at a frame boundary, so the line stays 0 until then.
- R2: Format code 00 is left-justified. Channel 0 (bits 23:0 of `smp_data`) is sent while the frame sync is high, and channel 1 (bits 47:24) while it is low. The MSB is sent in bit period 0 and the LSB in bit period 23. Bit periods 24 and later send 0.
- R3: Format code 01 is I2S. Channel 0 is sent while the frame sync is low, and channel 1 while it is high. Bit period 0 sends 0. The MSB is sent in bit period 1 and the LSB in bit period 24. Later bit periods send 0.
- R4: Format code 10 is TDM. A rising frame sync starts a frame of four 32-period slots, sent in the order channel 0, 1, 2, 3 (channel k is bits 24k+23:24k). Each slot sends its word MSB first in the slot's first 24 periods, followed by 8 zero periods.
- R5: In TDM mode a falling frame sync has no effect on the frame in progress. After the fourth slot the line stays 0 until the next rising frame sync.
- R6: Format code 11 is reserved and holds `sdout` at 0.
- R7: `sdout` changes only in the system-clock cycle that follows a detected bit-clock falling edge. It is stable while the bit clock is high.
- R8: A load on `smp_valid` is held in staging. It becomes active at the next frame start, which is a rising frame sync for codes 00 and 10 and a falling frame sync for code 01. A load in the middle of a frame leaves the current frame's bits unchanged and appears in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master, synchronous to clk |
| fs | input | 1 | Frame sync from the external master, changes with bclk falling |
| fmt | input | 2 | Format code: 00 left-justified, 01 I2S, 10 TDM, 11 reserved |
| smp_valid | input | 1 | One-cycle strobe that loads `smp_data` into staging |
| smp_data | input | 96 | Four 24-bit sample words, channel 0 in the lowest bits |
| sdout | output | 1 | Serial data line |

## Verification
The assertions assume three things about the inputs. Each bit-clock level lasts several system-clock cycles. The frame sync changes only while the bit clock is low. The format code stays fixed within a frame. Under these conditions the edge detection sees every bit-clock edge exactly once. The stimulus meets them by building every bit period as four system cycles low and four high. It moves the frame sync only together with the bit-clock falling edge, and it changes the format code only during preamble periods whose output is not scored. Sample loads are placed away from the frame-start period, so staging and latching never collide within one cycle.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    FMT_LJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_TDM = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;

  // Bit counter restarts: TDM restarts on rising sync only; two-channel
  // formats restart on either sync edge (one half-frame per level).
  function automatic logic restart_on(input fmt_e f, input logic rise, input logic fall);
    case (f)
      FMT_TDM: return rise;
      default: return rise | fall;
    endcase
  endfunction

  // Frame start (staging -> active words).
  function automatic logic latch_on(input fmt_e f, input logic rise, input logic fall);
    case (f)
      FMT_LJ:  return rise;
      FMT_I2S: return fall;
      FMT_TDM: return rise;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tx_clk_events.sv
module tx_clk_events (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fs,
  output logic fall_ev,
  output logic fs_now,
  output logic fs_prev
);
  logic bclk_q;
  logic rise_ev;

  assign rise_ev = bclk & ~bclk_q;
  assign fall_ev = ~bclk & bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      fs_now  <= 1'b0;
      fs_prev <= 1'b0;
    end else begin
      bclk_q <= bclk;
      if (rise_ev) begin
        fs_now  <= fs;
        fs_prev <= fs_now;
      end
    end
  end
endmodule

// File: rtl/tx_word_hold.sv
module tx_word_hold #(
  parameter int DATA_W = 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              latch,
  output logic [DATA_W-1:0] hold,
  output logic [DATA_W-1:0] cur
);
  logic [DATA_W-1:0] stage;

  // Words in use for the bit being chosen this cycle.
  assign cur = latch ? stage : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
      hold  <= '0;
    end else begin
      if (load)  stage <= din;
      if (latch) hold  <= stage;
    end
  end
endmodule

// File: rtl/tx_bit_pick.sv
module tx_bit_pick
  import audio_tx_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WORD_W = 24,
  parameter int SLOT_W = 32,
  parameter int CNT_W  = 8
) (
  input  fmt_e                     fmt,
  input  logic                     fs_now,
  input  logic [CNT_W-1:0]         idx,
  input  logic [N_CH*WORD_W-1:0]   words,
  output logic                     bit_o
);
  localparam int TDM_LEN = N_CH * SLOT_W;

  // MSB-first bit at position pos; positions outside the word are zero fill.
  function automatic logic word_bit(input logic [WORD_W-1:0] w, input int pos);
    if (pos < 0 || pos >= WORD_W) return 1'b0;
    return w[WORD_W-1-pos];
  endfunction

  logic [WORD_W-1:0] ch0_w;
  logic [WORD_W-1:0] ch1_w;
  int                n;
  int                slot;

  assign ch0_w = words[WORD_W-1:0];
  assign ch1_w = words[2*WORD_W-1:WORD_W];

  always_comb begin
    n     = int'(idx);
    slot  = n / SLOT_W;
    bit_o = 1'b0;
    case (fmt)
      FMT_LJ:  bit_o = word_bit(fs_now ? ch0_w : ch1_w, n);
      FMT_I2S: bit_o = word_bit(fs_now ? ch1_w : ch0_w, n - 1);
      FMT_TDM: begin
        if (n < TDM_LEN)
          bit_o = word_bit(words[slot*WORD_W +: WORD_W], n % SLOT_W);
      end
      default: bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int WORD_W = 24,
  parameter int SLOT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bclk,
  input  logic                   fs,
  input  logic [1:0]             fmt,
  input  logic                   smp_valid,
  input  logic [N_CH*WORD_W-1:0] smp_data,
  output logic                   sdout
);
  localparam int DATA_W  = N_CH * WORD_W;
  localparam int TDM_LEN = N_CH * SLOT_W;
  localparam int CNT_W   = $clog2(TDM_LEN) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  fmt_e              fmt_c;
  logic              fall_ev;
  logic              fs_now;
  logic              fs_prev;
  logic              fs_rise;
  logic              fs_fall;
  logic              frame_edge;
  logic              latch;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  idx_nxt;
  logic [DATA_W-1:0] hold_words;
  logic [DATA_W-1:0] cur_words;
  logic              bit_nxt;

  assign fmt_c      = fmt_e'(fmt);
  assign fs_rise    = fs_now & ~fs_prev;
  assign fs_fall    = ~fs_now & fs_prev;
  assign frame_edge = restart_on(fmt_c, fs_rise, fs_fall);
  assign latch      = fall_ev & latch_on(fmt_c, fs_rise, fs_fall);
  assign idx_nxt    = frame_edge ? '0 :
                      (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  tx_clk_events u_ev (
    .clk     (clk),
    .rst_n   (rst_n),
    .bclk    (bclk),
    .fs      (fs),
    .fall_ev (fall_ev),
    .fs_now  (fs_now),
    .fs_prev (fs_prev)
  );

  tx_word_hold #(.DATA_W(DATA_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (smp_valid),
    .din   (smp_data),
    .latch (latch),
    .hold  (hold_words),
    .cur   (cur_words)
  );

  tx_bit_pick #(
    .N_CH   (N_CH),
    .WORD_W (WORD_W),
    .SLOT_W (SLOT_W),
    .CNT_W  (CNT_W)
  ) u_pick (
    .fmt    (fmt_c),
    .fs_now (fs_now),
    .idx    (idx_nxt),
    .words  (cur_words),
    .bit_o  (bit_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_MAX;
      sdout <= 1'b0;
    end else if (fall_ev) begin
      cnt_q <= idx_nxt;
      sdout <= bit_nxt;
    end
  end
endmodule

// File: rtl/tx_checks.sv
module tx_checks #(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 96,
  parameter int TDM_LEN = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        fmt,
  input logic              sdout,
  input logic              fall_ev,
  input logic              frame_edge,
  input logic              latch,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] hold
);
  // R1
  rst_zero_chk: assert property (@(posedge clk) !rst_n |=> !sdout);

  // R3
  i2s_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'b01 && fall_ev && frame_edge) |=> !sdout);

  // R5
  tdm_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'b10 && fall_ev && !frame_edge && int'(cnt_q) >= TDM_LEN - 1) |=> !sdout);

  // R6
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt == 2'b11 && fall_ev) |=> !sdout);

  // R7
  sdout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdout));

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(hold));
endmodule

bind audio_serial_tx tx_checks #(
  .CNT_W   (CNT_W),
  .DATA_W  (DATA_W),
  .TDM_LEN (TDM_LEN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fmt        (fmt),
  .sdout      (sdout),
  .fall_ev    (fall_ev),
  .frame_edge (frame_edge),
  .latch      (latch),
  .cnt_q      (cnt_q),
  .hold       (hold_words)
);

// File: tb/sim_audio_serial_tx.sv
module sim_audio_serial_tx;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fs = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic        smp_valid = 1'b0;
  logic [95:0] smp_data = '0;
  logic        sdout;

  always #(CLK_NS/2) clk = ~clk;

  audio_serial_tx u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk      (bclk),
    .fs        (fs),
    .fmt       (fmt),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .sdout     (sdout)
  );

  typedef struct {
    bit    care;
    bit    val;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  logic  held = 1'b0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  task automatic check(input logic act, input logic expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: sdout=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  // Monitor: capture like a receiver on bclk rising, score against queue.
  initial begin
    exp_t e;
    forever begin
      @(posedge bclk);
      held   = sdout;
      mon_on = 1'b1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        if (e.care) check(sdout, e.val, e.tag);
      end
    end
  end

  // R7: line must not move while bclk is high.
  initial begin
    forever begin
      @(negedge bclk);
      if (mon_on) check(sdout, held, "R7");
    end
  end

  function automatic logic [23:0] mkword(input int s, input int fr, input int ch);
    logic [31:0] h;
    h = 32'(s) * 32'h9E3779B1 + 32'(fr) * 32'h85EBCA77 + 32'(ch) * 32'hC2B2AE3D + 32'h1234567;
    h = h ^ (h >> 13);
    h = h * 32'h2545F491;
    h = h ^ (h >> 16);
    if (ch == 0 && fr == 0) return h[23:0] | 24'h800001;
    return h[23:0];
  endfunction

  function automatic logic [95:0] pack(input int s, input int fr);
    logic [95:0] p;
    for (int ch = 0; ch < 4; ch++) p[ch*24 +: 24] = mkword(s, fr, ch);
    return p;
  endfunction

  // Expected bit captured at frame cycle c (c = 1 .. frame length).
  function automatic logic expbit(input logic [1:0] f, input int c, input logic [95:0] d);
    int p;
    int ch;
    case (f)
      2'b00: begin
        ch = (c <= 32) ? 0 : 1;
        p  = (c <= 32) ? c - 1 : c - 33;
      end
      2'b01: begin
        if (c == 1) return 1'b0;
        ch = (c <= 33) ? 0 : 1;
        p  = (c <= 33) ? c - 2 : c - 34;
      end
      2'b10: begin
        p = c - 1;
        if (p >= 128) return 1'b0;
        ch = p / 32;
        p  = p % 32;
      end
      default: return 1'b0;
    endcase
    if (p >= 24) return 1'b0;
    return d[ch*24 + 23 - p];
  endfunction

  task automatic bit_cycle(input logic f, input bit ld, input logic [95:0] d);
    @(negedge clk);
    bclk = 1'b0;
    fs   = f;
    if (ld) begin
      smp_valid = 1'b1;
      smp_data  = d;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input bit care, input logic v, input string tag);
    exp_t e;
    e.care = care;
    e.val  = v;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Driver: queue expected bits for all frames, then drive bclk/fs/loads.
  task automatic run_stream(input logic [1:0] f, input int nfr, input int flen,
                            input int act_len, input logic act, input bit do_load,
                            input int s, input string tag);
    logic        idle;
    logic        fsv;
    logic [95:0] d;
    string       t;
    idle = ~act;
    fsv  = idle;
    repeat (3) push(1'b0, 1'b0, "");
    for (int fr = 0; fr < nfr; fr++) begin
      d = do_load ? pack(s, fr) : '0;
      for (int c = 1; c <= flen; c++) begin
        if (f == 2'b10 && c > 128) t = "R5";
        else if (fr > 0)           t = {tag, "/R8"};
        else                       t = tag;
        push(1'b1, expbit(f, c, d), t);
      end
    end
    @(negedge clk);
    fmt = f;
    bit_cycle(idle, do_load, pack(s, 0));
    bit_cycle(idle, 1'b0, '0);
    for (int fr = 0; fr < nfr; fr++) begin
      for (int c = 0; c < flen; c++) begin
        fsv = (c < act_len) ? act : idle;
        bit_cycle(fsv, do_load && c == 20 && fr + 1 < nfr, pack(s, fr + 1));
      end
    end
    bit_cycle(fsv, 1'b0, '0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check(sdout, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sdout, 1'b0, "R1");
    // R1: no load yet, line must stay zero through a frame
    run_stream(2'b00, 1, 64, 32, 1'b1, 1'b0, 0, "R1");
    // R2: left-justified, three frames with mid-frame reloads
    run_stream(2'b00, 3, 64, 32, 1'b1, 1'b1, 1, "R2");
    // R3: I2S, left while sync low
    run_stream(2'b01, 3, 64, 32, 1'b0, 1'b1, 2, "R3");
    // R4: TDM with a one-period sync pulse
    run_stream(2'b10, 2, 128, 1, 1'b1, 1'b1, 3, "R4");
    // R5: TDM with sync falling mid-frame (ignored)
    run_stream(2'b10, 2, 128, 64, 1'b1, 1'b1, 4, "R5");
    // R4/R5: TDM frame longer than four slots, tail is zero
    run_stream(2'b10, 2, 136, 1, 1'b1, 1'b1, 5, "R4");
    // R6: reserved code
    run_stream(2'b11, 1, 64, 32, 1'b1, 1'b1, 6, "R6");
    // R2: back to left-justified after reserved
    run_stream(2'b00, 2, 64, 32, 1'b1, 1'b1, 7, "R2");
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): run=unfinished expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule